// File: doc/BRIEF.md
# Per-Pin Configurable I/O Port with Interrupt Detection

This block controls a bank of general-purpose pins, eight by default. Each pin has its own configuration entry, written over a single-cycle register bus. The entry selects one of eight behaviours: plain input, push-pull output, open-drain output, open-source output, pass-through for an on-chip peripheral, level interrupt, single-edge interrupt or dual-edge interrupt. A polarity bit sets the active level, or the active edge for the single-edge mode.

Pad inputs pass through a two-flop synchroniser. A third register keeps the previous synchronised value for edge detection. Each interrupt-mode pin has a status bit. Edge status bits are sticky and are cleared by writing 1 to them. A level status bit follows the pin. The block ORs the status bits of all pins in an interrupt mode into one request line. Outputs are a pad value and a pad enable for each pin. Pad electrical features are handled outside the block.

The register window has four parts. Address 0 holds the output data. Address 1 reads the synchronised pad inputs. Address 2 is the interrupt status. Address 4+i is the configuration of pin i. Reads are combinational on the address.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every configuration entry, the data register and every status bit are 0, and pad_oe and irq are 0.
- R2: A write to address 4+i stores bus_wdata[3:0] as the configuration of pin i, and a read of that address returns it zero-extended. Bits [2:0] select the mode (0 input, 1 push-pull, 2 open-drain, 3 open-source, 4 pass-through, 5 level interrupt, 6 edge interrupt, 7 dual edge). Bit 3 is the polarity (1 = high level or rising edge).
- R3: In push-pull mode the pin's pad_oe is 1 and its pad_out equals bit i of the data register (address 0).
- R4: In open-drain mode pad_out is 0 and pad_oe is the inverse of the data bit.
- R5: In open-source mode pad_out is 1 and pad_oe equals the data bit.
- R6: In pass-through mode pad_out and pad_oe equal alt_out[i] and alt_oe[i] in the same cycle. alt_out and alt_oe of pins in any other mode have no effect.
- R7: Address 1 returns pad_in as sampled two clock edges earlier.
- R8: In level-interrupt mode the status bit becomes equal to (pin == polarity) three edges after the pad changes and follows it from then on. Writing 1 to it has no lasting effect while the level stays active.
- R9: In edge-interrupt mode, a rising edge (polarity 1) or a falling edge (polarity 0) sets the status bit three edges after the pad change. The opposite edge does not set it, and once set the bit stays set.
- R10: In dual-edge mode both rising and falling pad changes set the status bit.
- R11: Writing address 2 clears the edge status bits whose write-data bit is 1. Bits written with 0 are untouched. A set and a clear of the same bit at the same edge leave the bit set.
- R12: irq is the OR of the status bits of pins in interrupt modes. Pins in any other mode keep status 0. Writing a pin's configuration clears its status bit.
- R13: Pins are configured independently: writing one pin's entry changes neither the configuration nor the pad drive of another pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Peripheral output values for pass-through pins |
| alt_oe | input | NPINS | Peripheral output enables for pass-through pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each pad input is a clean level between clock edges: if a change shorter than a cycle is lost by the synchroniser, the sticky-status and sync-delay properties still hold but no longer describe the pin. They also assume that a bus write lasts one cycle and that a write to the status address and a configuration write are separate events. The stimulus changes pads only just after a rising edge, and holds every level for at least three cycles before it is checked. It issues each write as a one-cycle strobe. In one case it aligns a clear with a set on purpose to exercise the set-wins rule.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    typedef enum logic [2:0] {
        PM_INPUT  = 3'd0,
        PM_PUSH   = 3'd1,
        PM_DRAIN  = 3'd2,
        PM_SOURCE = 3'd3,
        PM_ALT    = 3'd4,
        PM_LEVEL  = 3'd5,
        PM_EDGE   = 3'd6,
        PM_BOTH   = 3'd7
    } pin_mode_e;

    localparam int unsigned CFG_W        = 4;
    localparam int unsigned REG_DATA     = 0;
    localparam int unsigned REG_INPUT    = 1;
    localparam int unsigned REG_STATUS   = 2;
    localparam int unsigned REG_CFG_BASE = 4;

    function automatic logic mode_is_irq(input logic [2:0] m);
        return (m == PM_LEVEL) || (m == PM_EDGE) || (m == PM_BOTH);
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] last;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = raw_in;
        sy_d.stable = sy_q.meta;
        sy_d.last   = sy_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign cur_o  = sy_q.stable;
    assign prev_o = sy_q.last;
endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
    import pinbank_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       pol,
    input  logic       dout,
    input  logic       alt_out,
    input  logic       alt_oe,
    input  logic       cur,
    input  logic       prev,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       irq_en,
    output logic       is_level,
    output logic       hit
);
    logic rise, fall;

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        pad_out  = dout;
        pad_oe   = 1'b0;
        irq_en   = 1'b0;
        is_level = 1'b0;
        hit      = 1'b0;
        case (pin_mode_e'(mode))
            PM_PUSH: begin
                pad_oe = 1'b1;
            end
            PM_DRAIN: begin
                pad_out = 1'b0;
                pad_oe  = ~dout;
            end
            PM_SOURCE: begin
                pad_out = 1'b1;
                pad_oe  = dout;
            end
            PM_ALT: begin
                pad_out = alt_out;
                pad_oe  = alt_oe;
            end
            PM_LEVEL: begin
                irq_en   = 1'b1;
                is_level = 1'b1;
                hit      = (cur == pol);
            end
            PM_EDGE: begin
                irq_en = 1'b1;
                hit    = pol ? rise : fall;
            end
            PM_BOTH: begin
                irq_en = 1'b1;
                hit    = rise | fall;
            end
            default: begin
                pad_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic              irq
);
    localparam int unsigned PAD_W = NPINS - CFG_W;

    typedef struct packed {
        logic [NPINS-1:0]            dout;
        logic [NPINS-1:0][CFG_W-1:0] cfg;
        logic [NPINS-1:0]            status;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] in_sync, in_prev;
    logic [NPINS-1:0] irq_en, lvl, hit, cfg_wr;
    logic             data_wr, stat_wr;

    pinbank_sync #(.W(NPINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pad_in),
        .cur_o  (in_sync),
        .prev_o (in_prev)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pinbank_pin pin_i (
            .mode     (st_q.cfg[g][2:0]),
            .pol      (st_q.cfg[g][3]),
            .dout     (st_q.dout[g]),
            .alt_out  (alt_out[g]),
            .alt_oe   (alt_oe[g]),
            .cur      (in_sync[g]),
            .prev     (in_prev[g]),
            .pad_out  (pad_out[g]),
            .pad_oe   (pad_oe[g]),
            .irq_en   (irq_en[g]),
            .is_level (lvl[g]),
            .hit      (hit[g])
        );
        assign cfg_wr[g] = bus_we && (bus_addr == ADDR_W'(REG_CFG_BASE + g));
    end

    assign data_wr = bus_we && (bus_addr == ADDR_W'(REG_DATA));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(REG_STATUS));

    always_comb begin
        st_d = st_q;
        if (data_wr) st_d.dout = bus_wdata;
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_wr[i]) st_d.cfg[i] = bus_wdata[CFG_W-1:0];
            if (!irq_en[i] || cfg_wr[i]) begin
                st_d.status[i] = 1'b0;
            end else if (lvl[i]) begin
                st_d.status[i] = hit[i];
            end else begin
                st_d.status[i] = hit[i] | (st_q.status[i] & ~(stat_wr & bus_wdata[i]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |(st_q.status & irq_en);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_DATA))   bus_rdata = st_q.dout;
        if (bus_addr == ADDR_W'(REG_INPUT))  bus_rdata = in_sync;
        if (bus_addr == ADDR_W'(REG_STATUS)) bus_rdata = st_q.status;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == ADDR_W'(REG_CFG_BASE + i)) bus_rdata = {{PAD_W{1'b0}}, st_q.cfg[i]};
        end
    end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [NPINS-1:0]                bus_wdata,
    input logic [NPINS-1:0]                pad_in,
    input logic [NPINS-1:0]                pad_out,
    input logic [NPINS-1:0]                pad_oe,
    input logic [NPINS-1:0]                alt_out,
    input logic [NPINS-1:0]                alt_oe,
    input logic                            irq,
    input logic [NPINS-1:0][CFG_W-1:0]     cfg,
    input logic [NPINS-1:0]                status,
    input logic [NPINS-1:0]                sync_cur
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1 and R12: a request always has a status bit behind it
    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R7: synchronised input lags the pad by two edges
    p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (sync_cur == $past(pad_in, 2)));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        logic clr_g, cfgw_g;
        assign clr_g  = bus_we && (bus_addr == ADDR_W'(REG_STATUS)) && bus_wdata[g];
        assign cfgw_g = bus_we && (bus_addr == ADDR_W'(REG_CFG_BASE + g));

        // R4
        p_drain_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g][2:0] == PM_DRAIN && pad_oe[g]) |-> !pad_out[g]);

        // R5
        p_source_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g][2:0] == PM_SOURCE && pad_oe[g]) |-> pad_out[g]);

        // R6
        p_alt_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g][2:0] == PM_ALT) |-> (pad_out[g] == alt_out[g] && pad_oe[g] == alt_oe[g]));

        // R3
        p_push_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[g][2:0] == PM_PUSH) |-> pad_oe[g]);

        // R12: non-interrupt pins hold no status
        p_quiet_nonirq_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_is_irq(cfg[g][2:0]) |=> !status[g]);

        // R9 and R10: edge status is sticky until cleared
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg[g][2:0] == PM_EDGE || cfg[g][2:0] == PM_BOTH) && status[g] && !clr_g && !cfgw_g)
            |=> status[g]);
    end
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe),
    .irq       (irq),
    .cfg       (st_q.cfg),
    .status    (st_q.status),
    .sync_cur  (in_sync)
);

// File: tb/pinbank_ctrl_tb_top.sv
module pinbank_ctrl_tb_top;
    localparam int NP = 8;
    localparam int AW = 4;
    localparam int A_DATA = 0, A_IN = 1, A_ST = 2, A_CFG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [NP-1:0] alt_out = '0, alt_oe = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int       req;
        int       sel;
        logic [7:0] exp;
        logic [7:0] mask;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    pinbank_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .irq(irq)
    );

    // monitor: pops expectations and compares away from the rising edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] obs;
            it = sb_q.pop_front();
            case (it.sel)
                0: obs = pad_out;
                1: obs = pad_oe;
                2: obs = {7'b0, irq};
                default: obs = bus_rdata;
            endcase
            checks++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                errors++;
                $display("FAIL R%0d sel=%0d actual=%h expected=%h mask=%h",
                         it.req, it.sel, obs & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input int sel, input logic [7:0] exp, input logic [7:0] mask, input int req);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.mask = mask;
        sb_q.push_back(it);
    endtask

    task automatic rd_chk(input int addr, input logic [7:0] exp, input logic [7:0] mask, input int req);
        bus_addr = AW'(addr);
        #1;
        chk(3, exp, mask, req);
        settle();
    endtask

    task automatic wr(input int addr, input logic [7:0] data);
        bus_addr  = AW'(addr);
        bus_wdata = data;
        bus_we    = 1'b1;
        cyc(1);
        bus_we    = 1'b0;
        bus_addr  = AW'(A_ST);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(1, 8'h00, 8'hFF, 1);
        chk(2, 8'h00, 8'h01, 1);
        settle();
        rd_chk(A_ST, 8'h00, 8'hFF, 1);
        rd_chk(A_CFG, 8'h00, 8'hFF, 1);
        rd_chk(A_DATA, 8'h00, 8'hFF, 1);

        // R2 configuration and readback
        wr(A_CFG + 0, 8'h01);
        rd_chk(A_CFG + 0, 8'h01, 8'hFF, 2);
        wr(A_CFG + 1, 8'h02);
        wr(A_CFG + 2, 8'h03);
        wr(A_CFG + 3, 8'h04);
        wr(A_CFG + 4, 8'h0D);
        rd_chk(A_CFG + 4, 8'h0D, 8'hFF, 2);

        // R4 R5 R13 with data 0: push pin0 oe, drain pin1 oe, source pin2 released
        chk(1, 8'h03, 8'hFF, 13);
        chk(0, 8'h04, 8'h07, 4);
        settle();
        wr(A_DATA, 8'h07);
        chk(0, 8'h01, 8'h01, 3);  // R3
        chk(1, 8'h01, 8'h01, 3);
        chk(1, 8'h00, 8'h02, 4);  // R4 released on 1
        chk(0, 8'h04, 8'h04, 5);  // R5
        chk(1, 8'h04, 8'h04, 5);
        settle();

        // R6 pass-through
        alt_out = 8'h08; alt_oe = 8'h08; #1;
        chk(0, 8'h08, 8'h08, 6);
        chk(1, 8'h08, 8'h08, 6);
        settle();
        alt_out = 8'hF7; alt_oe = 8'hFF; #1;
        chk(0, 8'h05, 8'h0F, 6);
        chk(1, 8'h0D, 8'hFF, 6);
        settle();
        alt_out = 8'h00; alt_oe = 8'h00;

        // R7 input synchroniser
        cyc(1);
        pad_in = 8'hA5;
        bus_addr = AW'(A_IN);
        cyc(1);
        chk(3, 8'h00, 8'hFF, 7);
        settle();
        cyc(1);
        chk(3, 8'hA5, 8'hFF, 7);
        settle();
        pad_in = 8'h00;
        cyc(3);
        bus_addr = AW'(A_ST);

        // R8 level high on pin4
        pad_in[4] = 1'b1;
        cyc(2);
        chk(3, 8'h00, 8'h10, 8);
        chk(2, 8'h00, 8'h01, 8);
        settle();
        cyc(1);
        chk(3, 8'h10, 8'h10, 8);
        chk(2, 8'h01, 8'h01, 12);
        settle();
        wr(A_ST, 8'h10);
        chk(3, 8'h10, 8'h10, 8);
        settle();
        pad_in[4] = 1'b0;
        cyc(3);
        chk(3, 8'h00, 8'h10, 8);
        chk(2, 8'h00, 8'h01, 8);
        settle();
        wr(A_CFG + 4, 8'h05);   // level low
        cyc(1);
        chk(3, 8'h10, 8'h10, 8);
        settle();
        wr(A_CFG + 4, 8'h00);
        cyc(1);
        chk(3, 8'h00, 8'h10, 12);
        chk(2, 8'h00, 8'h01, 12);
        settle();

        // R9 rising edge on pin5
        wr(A_CFG + 5, 8'h0E);
        pad_in[5] = 1'b1;
        cyc(2);
        chk(3, 8'h00, 8'h20, 9);
        settle();
        cyc(1);
        chk(3, 8'h20, 8'h20, 9);
        chk(2, 8'h01, 8'h01, 9);
        settle();
        pad_in[5] = 1'b0;
        cyc(4);
        chk(3, 8'h20, 8'h20, 9);
        settle();
        wr(A_ST, 8'h00);        // R11 zero write ignored
        chk(3, 8'h20, 8'h20, 11);
        settle();
        wr(A_ST, 8'h20);
        chk(3, 8'h00, 8'h20, 11);
        chk(2, 8'h00, 8'h01, 11);
        settle();

        // R9 falling edge on pin6
        wr(A_CFG + 6, 8'h06);
        pad_in[6] = 1'b1;
        cyc(4);
        chk(3, 8'h00, 8'h40, 9);
        settle();
        cyc(1);
        pad_in[6] = 1'b0;
        cyc(3);
        chk(3, 8'h40, 8'h40, 9);
        settle();
        wr(A_ST, 8'h40);

        // R10 dual edge on pin7
        wr(A_CFG + 7, 8'h07);
        pad_in[7] = 1'b1;
        cyc(3);
        chk(3, 8'h80, 8'h80, 10);
        settle();
        wr(A_ST, 8'h80);
        chk(3, 8'h00, 8'h80, 10);
        settle();
        cyc(1);
        pad_in[7] = 1'b0;
        cyc(2);
        chk(3, 8'h00, 8'h80, 10);
        settle();
        cyc(1);
        chk(3, 8'h80, 8'h80, 10);
        settle();
        wr(A_ST, 8'h80);

        // R11 set wins over clear in the same edge
        pad_in[7] = 1'b1;
        cyc(2);
        wr(A_ST, 8'h80);
        chk(3, 8'h80, 8'h80, 11);
        settle();
        wr(A_ST, 8'h80);
        chk(3, 8'h00, 8'hFF, 11);
        settle();

        // R12 configuration write clears status; non-interrupt pin keeps 0
        cyc(1);
        pad_in[5] = 1'b1;
        cyc(3);
        chk(3, 8'h20, 8'h20, 12);
        settle();
        wr(A_CFG + 5, 8'h0E);
        chk(3, 8'h00, 8'h20, 12);
        chk(2, 8'h00, 8'h01, 12);
        settle();
        cyc(1);
        pad_in[0] = 1'b1;
        cyc(4);
        chk(3, 8'h00, 8'h01, 12);
        chk(2, 8'h00, 8'h01, 12);
        settle();

        // R13 independence
        wr(A_CFG + 1, 8'h01);
        chk(1, 8'h07, 8'h07, 13);
        chk(0, 8'h07, 8'h07, 13);
        settle();
        rd_chk(A_CFG + 0, 8'h01, 8'hFF, 13);
        rd_chk(A_CFG + 2, 8'h03, 8'hFF, 13);

        cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule